// File: doc/BRIEF.md
# Register-Controlled Bidirectional Pin Port

This block is an eight-pin general-purpose I/O port that a host drives through a small synchronous register bus. Five byte-wide registers are reachable on that bus: a pin-level view, a per-pin direction register, an output latch, an analog-select register and a slew-control register. The block turns these into a per-pin output enable and output value for the pad ring, and it brings each pad's input level back through a two-stage synchronizer so the host can read it.

Reads of the pin-level view and of the output latch are deliberately distinct. Software doing read-modify-write on the latch always works on the intended drive value, even when a pin is loaded and its sampled level differs. Pins marked analog read as zero in the pin-level view, but their drivers still follow the direction bits. A static configuration input can hand the two top pins to an oscillator function. The block then hides those pins in three of the registers and forces their drivers off, while still keeping whatever software writes to them.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1, so all output enables are 0. The output latch and the slew register are 0, and the analog-select register is 0x2F (pins 5 and 3..0 analog, pin 4 digital).
- R2: The register map is: address 0 pin level, 1 direction, 2 output latch, 3 analog select, 4 slew control. A write takes effect on the clock edge that samples the write strobe.
- R3: For a pin not claimed by the oscillator, a direction bit of 0 drives `pad_oe` high for that pin. A direction bit of 1 drives it low. `pad_out` always carries the output latch.
- R4: A write to address 0 or to address 2 loads the output latch. A read of address 2 returns the latch, not the pin level.
- R5: A read of address 0 returns the pad input levels after a two-flop synchronizer. A pad change becomes visible after the second rising clock edge, and not after the first.
- R6: Any pin whose analog-select bit is 1 reads as 0 at address 0.
- R7: A pin selected as analog still has its output enable controlled by its direction bit.
- R8: While `osc_claim` is 1, bits 7 and 6 read as 0 at addresses 0, 1 and 2, and `pad_oe[7:6]` is 0 whatever the direction bits hold.
- R9: Writes to bits 7 and 6 of the direction register and latch are stored while `osc_claim` is 1. They read back and take effect once `osc_claim` returns to 0.
- R10: The slew register is plain read/write storage, and its value appears on `slew_ctl`.
- R11: `bus_rdata` is 0 whenever `bus_rd` is 0, and for reads of addresses 5 to 7.
- R12: A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Combinational read data |
| osc_claim | input | 1 | Pins 7 and 6 belong to the oscillator |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |
| slew_ctl | output | 8 | Per-pin slew-rate control |

## Verification
Two things can meet in one cycle. The first is a register read with a write to the same register, where the read must show the pre-write contents. The second is a pin-level read while a pad edge is still in the synchronizer, where the read must show the older level for one more edge. The bench raises the read and write strobes together on the latch and direction registers. It also changes `pad_in` and then reads address 0 after one edge and after two. A behavioural model built from the requirements checks every cycle, and directed checks cover the edge cases, oscillator masking among them.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W          = 8,
  parameter int AW         = 3,
  parameter logic [7:0] ANA_RST = 8'h2F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [W-1:0]  bus_rdata,
  input  logic          osc_claim,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  slew_ctl
);
  localparam logic [AW-1:0] A_PIN = AW'(0);
  localparam logic [AW-1:0] A_DIR = AW'(1);
  localparam logic [AW-1:0] A_LAT = AW'(2);
  localparam logic [AW-1:0] A_ANA = AW'(3);
  localparam logic [AW-1:0] A_SLW = AW'(4);
  localparam logic [W-1:0]  KEEP_LOW = {2'b00, {(W-2){1'b1}}};

  logic [W-1:0] dir_q, lat_q, ana_q, slw_q;
  logic [W-1:0] meta_q, sync_q;
  logic [W-1:0] osc_mask, pin_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= W'(ANA_RST);
      slw_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_PIN, A_LAT: lat_q <= bus_wdata;
        A_DIR:        dir_q <= bus_wdata;
        A_ANA:        ana_q <= bus_wdata;
        A_SLW:        slw_q <= bus_wdata;
        default:      ;
      endcase
    end
  end

  assign osc_mask = osc_claim ? KEEP_LOW : '1;
  assign pin_view = sync_q & ~ana_q & osc_mask;

  assign pad_oe   = ~dir_q & osc_mask;
  assign pad_out  = lat_q;
  assign slew_ctl = slw_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_PIN:   bus_rdata = pin_view;
        A_DIR:   bus_rdata = dir_q & osc_mask;
        A_LAT:   bus_rdata = lat_q & osc_mask;
        A_ANA:   bus_rdata = ana_q;
        A_SLW:   bus_rdata = slw_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [W-1:0]  bus_rdata,
  input logic          osc_claim,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  slew_ctl,
  input logic [W-1:0]  ana_q
);
  // R8
  osc_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_claim |-> pad_oe[W-1:W-2] == 2'b00);

  // R4
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == AW'(0) || bus_addr == AW'(2))) |=> pad_out == $past(bus_wdata));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1) && !osc_claim) ##1 !osc_claim |-> pad_oe == ~$past(bus_wdata));

  // R6
  ana_pin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(0)) |-> (bus_rdata & ana_q) == '0);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_addr > AW'(4)) |-> bus_rdata == '0);

  // R10
  slew_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> slew_ctl == $past(bus_wdata));

  // R12
  rw_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr && bus_addr == AW'(4)) |-> bus_rdata == slew_ctl);
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .osc_claim(osc_claim), .pad_oe(pad_oe), .pad_out(pad_out),
  .slew_ctl(slew_ctl), .ana_q(ana_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       osc_claim = 1'b0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, slew_ctl;

  int checks = 0, fails = 0;
  logic [7:0] rv;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .osc_claim(osc_claim), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .slew_ctl(slew_ctl)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  logic [7:0] m_dir, m_lat, m_ana, m_slw;
  logic [7:0] m_hist [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= 8'hFF; m_lat <= 8'h00; m_ana <= 8'h2F; m_slw <= 8'h00;
      m_hist[0] <= 8'h00; m_hist[1] <= 8'h00;
    end else begin
      m_hist[0] <= pad_in;
      m_hist[1] <= m_hist[0];
      if (bus_wr) begin
        if (bus_addr == 3'd0 || bus_addr == 3'd2) m_lat <= bus_wdata;
        else if (bus_addr == 3'd1) m_dir <= bus_wdata;
        else if (bus_addr == 3'd3) m_ana <= bus_wdata;
        else if (bus_addr == 3'd4) m_slw <= bus_wdata;
      end
    end
  end

  function automatic logic [7:0] hide(input logic [7:0] v);
    return osc_claim ? (v & 8'h3F) : v;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (!bus_rd) return 8'h00;
    case (int'(bus_addr))
      0: return hide(m_hist[1] & ~m_ana);
      1: return hide(m_dir);
      2: return hide(m_lat);
      3: return m_ana;
      4: return m_slw;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R3 oe model", pad_oe, hide(~m_dir));
    check("R3 out model", pad_out, m_lat);
    check("R10 slew model", slew_ctl, m_slw);
    check("R2 rdata model", bus_rdata, exp_rd());
  end

  task automatic acc(input logic wr, input logic rd, input logic [2:0] a,
                     input logic [7:0] d, output logic [7:0] r);
    @(negedge clk); #1;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #4 r = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] x;
    acc(1'b1, 1'b0, a, d, x);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] r);
    acc(1'b0, 1'b1, a, 8'h00, r);
  endtask

  task automatic idle();
    logic [7:0] x;
    acc(1'b0, 1'b0, 3'd0, 8'h00, x);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, rv); check("R1 dir reset", rv, 8'hFF);
    rd(3'd2, rv); check("R1 latch reset", rv, 8'h00);
    rd(3'd3, rv); check("R1 analog reset", rv, 8'h2F);
    rd(3'd4, rv); check("R1 slew reset", rv, 8'h00);
    check("R1 oe reset", pad_oe, 8'h00);
    // R3/R4 latch and direction
    wr(3'd2, 8'hA5);
    wr(3'd1, 8'h00);
    idle();
    check("R3 oe enabled", pad_oe, 8'hFF);
    check("R3 out latch", pad_out, 8'hA5);
    wr(3'd1, 8'h0F);
    idle();
    check("R3 oe partial", pad_oe, 8'hF0);
    wr(3'd0, 8'h3C);
    rd(3'd2, rv); check("R4 write via pin addr", rv, 8'h3C);
    // R5 synchronizer latency
    wr(3'd3, 8'h00);
    pad_in = 8'hC3;
    repeat (3) idle();
    rd(3'd0, rv); check("R4 pin vs latch", rv, 8'hC3);
    @(negedge clk); #1 pad_in = 8'h5A; bus_rd = 1'b1; bus_addr = 3'd0; bus_wr = 1'b0;
    @(negedge clk); #5 check("R5 one edge old", bus_rdata, 8'hC3);
    @(negedge clk); #5 check("R5 two edges new", bus_rdata, 8'h5A);
    // R6/R7 analog
    pad_in = 8'hFF;
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h0F);
    repeat (2) idle();
    rd(3'd0, rv); check("R6 analog reads zero", rv, 8'hF0);
    check("R7 analog oe", pad_oe, 8'hFF);
    // R8/R9 oscillator claim
    @(negedge clk); #1 osc_claim = 1'b1;
    rd(3'd0, rv); check("R8 pin hidden", rv, 8'h30);
    rd(3'd1, rv); check("R8 dir hidden", rv, 8'h00);
    check("R8 oe forced", pad_oe, 8'h3F);
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hC0);
    rd(3'd2, rv); check("R8 latch hidden", rv, 8'h3F);
    rd(3'd1, rv); check("R8 dir hidden 2", rv, 8'h00);
    @(negedge clk); #1 osc_claim = 1'b0; bus_rd = 1'b0;
    rd(3'd2, rv); check("R9 latch kept", rv, 8'hFF);
    rd(3'd1, rv); check("R9 dir kept", rv, 8'hC0);
    check("R9 oe restored", pad_oe, 8'h3F);
    // R10 slew
    wr(3'd4, 8'h5A);
    rd(3'd4, rv); check("R10 slew read", rv, 8'h5A);
    check("R10 slew port", slew_ctl, 8'h5A);
    // R11 unmapped / idle
    rd(3'd5, rv); check("R11 addr5", rv, 8'h00);
    rd(3'd7, rv); check("R11 addr7", rv, 8'h00);
    acc(1'b0, 1'b0, 3'd4, 8'h00, rv); check("R11 rd low", rv, 8'h00);
    // R12 same-cycle read and write
    acc(1'b1, 1'b1, 3'd2, 8'h11, rv); check("R12 latch old", rv, 8'hFF);
    rd(3'd2, rv); check("R12 latch new", rv, 8'h11);
    acc(1'b1, 1'b1, 3'd1, 8'h77, rv); check("R12 dir old", rv, 8'hC0);
    rd(3'd1, rv); check("R12 dir new", rv, 8'h77);
    acc(1'b1, 1'b1, 3'd4, 8'h99, rv); check("R12 slew old", rv, 8'h5A);
    rd(3'd4, rv); check("R12 slew new", rv, 8'h99);
    repeat (2) idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule